// File: doc/BRIEF.md
# Unified Pointer Access Router

This block serves one byte access made through a single 24-bit unified pointer. The requester gives the pointer, a small displacement of 0 to 3, a read or write flag and a write byte. The router adds the displacement, works out which of four downstream memories owns the resulting address, and forwards the access there. It then returns the read byte, or a completion flag for a write, to the requester. The same unified address map covers external data, the internal RAMs and program code.

Accesses that are not allowed finish in one cycle and no downstream port is touched. A write into code space is always refused. When the wide-addressing enable is low, only the bottom 64 KB of code, the 64 KB classic external data window and the 64 KB internal page can be reached. A refused read returns FFh. The block also has a separate combinational adder that advances a stored pointer by 1 to 4.

Top module: `uptr_router`

## Requirements
- R1: The effective address is reqPtr plus reqDisp (0..3), taken modulo 2^24, so FF:FFFE plus 3 gives 00:0001.
- R2: An effective address with bit 23 low and bits [22:16] not equal to 7Fh goes to port 0 (external data, dnReq[0]) with dnAddr equal to bits [22:0].
- R3: Effective addresses 7F:0000 to 7F:00FF go to port 1 (internal RAM, dnReq[1]) with dnAddr equal to the low 8 bits, zero extended.
- R4: Effective addresses 7F:0100 to 7F:FFFF go to port 2 (extended internal RAM, dnReq[2]) with dnAddr equal to the low 16 bits, zero extended.
- R5: An effective address with bit 23 high goes to port 3 (code, dnReq[3]) with dnAddr equal to bits [22:0].
- R6: A write whose effective address is in code space raises no dnReq line. It completes with rspDone and rspBlocked high one cycle after acceptance.
- R7: With wideEn low, an access to external data above 00:FFFF or to code above code offset 00:FFFF is refused. It raises no dnReq line, and one cycle after acceptance it gives rspDone, rspBlocked and rspData = FFh.
- R8: A forwarded access raises exactly one dnReq line. That line, dnAddr, dnWe and dnWdata stay steady until the matching dnAck bit is seen, and reqReady is low meanwhile.
- R9: The cycle after the selected dnAck bit is sampled high, rspDone pulses with rspBlocked low. For a read, rspData is the byte of that port's lane of dnRdata (port n at bits [8n+7:8n]).
- R10: incResult equals incPtr plus (incImm + 1), where incImm 0..3 encodes an increment of 1..4, taken modulo 2^24.
- R11: After reset, no dnReq line is high, rspDone is low and reqReady is high.
- R12: With wideEn high, external data addresses 01:0000 to 7E:FFFF and code above offset 00:FFFF are forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wideEn | input | 1 | Enables addressing beyond 64 KB |
| reqValid | input | 1 | Access request, taken when reqReady is high |
| reqReady | output | 1 | Router idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPtr | input | 24 | Unified pointer |
| reqDisp | input | 2 | Displacement 0..3 |
| reqWdata | input | 8 | Write byte |
| rspDone | output | 1 | One-cycle completion pulse |
| rspBlocked | output | 1 | Completion was a refused access |
| rspData | output | 8 | Read byte (FFh when refused) |
| dnReq | output | 4 | Per-port request, one-hot |
| dnAck | input | 4 | Per-port acknowledge |
| dnWe | output | 1 | Write enable to the selected port |
| dnAddr | output | 23 | Offset within the selected port |
| dnWdata | output | 8 | Write byte to the selected port |
| dnRdata | input | 32 | Read bytes, one lane per port |
| incPtr | input | 24 | Pointer to advance |
| incImm | input | 2 | Increment minus one |
| incResult | output | 24 | Advanced pointer |

## Verification
The bench targets the region edges where a displacement moves the address across a boundary. These cases are 7F:007E+3 into the upper internal RAM, 7F:00FF+1 into the extended RAM, 7F:FFFF+1 into code and FF:FFFE+3 wrapping to external data 00:0001. A router that dropped the carry or decoded the address before the add would send these accesses to the wrong port or offset. It also runs the same out-of-window addresses with the wide enable low and then high. An inverted enable check would either leak a downstream request or refuse a legal access. A write into code is checked for the absence of any request. An acknowledge delayed by several cycles checks that the request and address are held and not dropped early.

// File: rtl/uptr_pkg.sv
package uptr_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int DISP_W = 2;
  localparam int NPORT  = 4;

  typedef enum logic [1:0] {
    PORT_EXT  = 2'd0,
    PORT_IRAM = 2'd1,
    PORT_XRAM = 2'd2,
    PORT_CODE = 2'd3
  } portSel_t;

  typedef struct packed {
    logic accept;
    logic finishBlock;
    logic finishAck;
    logic drive;
  } ctrlStrobe_t;
endpackage

// File: rtl/uptr_decode.sv
module uptr_decode
  import uptr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DISP_W
) (
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] disp,
  input  logic          isWrite,
  input  logic          wideEn,
  output portSel_t      sel,
  output logic [AW-2:0] offset,
  output logic          blocked
);
  localparam int OFF_W  = AW - 1;
  localparam int PAGE_W = AW - 1 - 16;
  localparam logic [PAGE_W-1:0] INT_PAGE = {PAGE_W{1'b1}};

  logic [AW-1:0]     effAddr;
  logic [PAGE_W-1:0] page;
  logic              isCode;
  logic              isInt;

  always_comb begin
    effAddr = ptr + AW'(disp);
    isCode  = effAddr[AW-1];
    page    = effAddr[AW-2:16];
    isInt   = !isCode && (page == INT_PAGE);

    if (isCode) begin
      sel    = PORT_CODE;
      offset = effAddr[AW-2:0];
    end else if (isInt && effAddr[15:8] == 8'h00) begin
      sel    = PORT_IRAM;
      offset = OFF_W'(effAddr[7:0]);
    end else if (isInt) begin
      sel    = PORT_XRAM;
      offset = OFF_W'(effAddr[15:0]);
    end else begin
      sel    = PORT_EXT;
      offset = effAddr[AW-2:0];
    end

    blocked = (isCode && isWrite) ||
              (!wideEn && !isInt && (page != '0));
  end
endmodule

// File: rtl/uptr_datapath.sv
module uptr_datapath
  import uptr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = DATA_W,
  parameter int DW = DISP_W,
  parameter int NP = NPORT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wideEn,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqPtr,
  input  logic [DW-1:0]    reqDisp,
  input  logic [BW-1:0]    reqWdata,
  input  ctrlStrobe_t      strb,
  output logic             blockedNow,
  output logic             ackHit,
  output logic             rspDone,
  output logic             rspBlocked,
  output logic [BW-1:0]    rspData,
  output logic [NP-1:0]    dnReq,
  input  logic [NP-1:0]    dnAck,
  output logic             dnWe,
  output logic [AW-2:0]    dnAddr,
  output logic [BW-1:0]    dnWdata,
  input  logic [NP*BW-1:0] dnRdata,
  input  logic [AW-1:0]    incPtr,
  input  logic [1:0]       incImm,
  output logic [AW-1:0]    incResult
);
  portSel_t      decSel;
  logic [AW-2:0] decOffset;

  portSel_t      curSel;
  logic [AW-2:0] curAddr;
  logic          curWe;
  logic [BW-1:0] curWdata;
  logic [BW-1:0] laneData;

  uptr_decode #(.AW(AW), .DW(DW)) u_dec (
    .ptr     (reqPtr),
    .disp    (reqDisp),
    .isWrite (reqWrite),
    .wideEn  (wideEn),
    .sel     (decSel),
    .offset  (decOffset),
    .blocked (blockedNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSel   <= PORT_EXT;
      curAddr  <= '0;
      curWe    <= 1'b0;
      curWdata <= '0;
    end else if (strb.accept && !blockedNow) begin
      curSel   <= decSel;
      curAddr  <= decOffset;
      curWe    <= reqWrite;
      curWdata <= reqWdata;
    end
  end

  always_comb begin
    laneData = dnRdata[int'(curSel)*BW +: BW];
    ackHit   = dnAck[int'(curSel)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone    <= 1'b0;
      rspBlocked <= 1'b0;
      rspData    <= '1;
    end else begin
      rspDone    <= strb.finishBlock || strb.finishAck;
      rspBlocked <= strb.finishBlock;
      if (strb.finishBlock)
        rspData <= '1;
      else if (strb.finishAck)
        rspData <= laneData;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_req
    assign dnReq[p] = strb.drive && (int'(curSel) == p);
  end

  assign dnWe      = curWe;
  assign dnAddr    = curAddr;
  assign dnWdata   = curWdata;
  assign incResult = incPtr + AW'(incImm) + AW'(1);
endmodule

// File: rtl/uptr_ctrl.sv
module uptr_ctrl
  import uptr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        blockedNow,
  input  logic        ackHit,
  output logic        reqReady,
  output ctrlStrobe_t strb
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state, stateNext;

  always_comb begin
    strb.accept      = (state == ST_IDLE) && reqValid;
    strb.finishBlock = strb.accept && blockedNow;
    strb.drive       = (state == ST_WAIT);
    strb.finishAck   = (state == ST_WAIT) && ackHit;
    reqReady         = (state == ST_IDLE);

    stateNext = state;
    if (strb.accept && !blockedNow) stateNext = ST_WAIT;
    else if (strb.finishAck)        stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/uptr_router.sv
module uptr_router
  import uptr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = DATA_W,
  parameter int DW = DISP_W,
  parameter int NP = NPORT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wideEn,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqPtr,
  input  logic [DW-1:0]    reqDisp,
  input  logic [BW-1:0]    reqWdata,
  output logic             rspDone,
  output logic             rspBlocked,
  output logic [BW-1:0]    rspData,
  output logic [NP-1:0]    dnReq,
  input  logic [NP-1:0]    dnAck,
  output logic             dnWe,
  output logic [AW-2:0]    dnAddr,
  output logic [BW-1:0]    dnWdata,
  input  logic [NP*BW-1:0] dnRdata,
  input  logic [AW-1:0]    incPtr,
  input  logic [1:0]       incImm,
  output logic [AW-1:0]    incResult
);
  ctrlStrobe_t strb;
  logic        blockedNow;
  logic        ackHit;

  uptr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .blockedNow (blockedNow),
    .ackHit     (ackHit),
    .reqReady   (reqReady),
    .strb       (strb)
  );

  uptr_datapath #(.AW(AW), .BW(BW), .DW(DW), .NP(NP)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wideEn     (wideEn),
    .reqWrite   (reqWrite),
    .reqPtr     (reqPtr),
    .reqDisp    (reqDisp),
    .reqWdata   (reqWdata),
    .strb       (strb),
    .blockedNow (blockedNow),
    .ackHit     (ackHit),
    .rspDone    (rspDone),
    .rspBlocked (rspBlocked),
    .rspData    (rspData),
    .dnReq      (dnReq),
    .dnAck      (dnAck),
    .dnWe       (dnWe),
    .dnAddr     (dnAddr),
    .dnWdata    (dnWdata),
    .dnRdata    (dnRdata),
    .incPtr     (incPtr),
    .incImm     (incImm),
    .incResult  (incResult)
  );
endmodule

// File: rtl/uptr_checker.sv
module uptr_checker #(
  parameter int AW = 24,
  parameter int BW = 8,
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqReady,
  input logic [NP-1:0] dnReq,
  input logic [NP-1:0] dnAck,
  input logic          dnWe,
  input logic [AW-2:0] dnAddr,
  input logic [BW-1:0] dnWdata,
  input logic          rspDone,
  input logic          rspBlocked,
  input logic [BW-1:0] rspData
);
  // R8: never more than one port requested
  a_r8_one_port: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dnReq));

  // R8: request and its payload held until acknowledged
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    ((dnReq != '0) && ((dnReq & dnAck) == '0)) |=>
      ($stable(dnReq) && $stable(dnAddr) && $stable(dnWe) && $stable(dnWdata)));

  // R8: requester is not offered a new slot while a port is busy
  a_r8_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq != '0) |-> !reqReady);

  // R6: code port never sees a write
  a_r6_no_code_write: assert property (@(posedge clk) disable iff (!rstN)
    dnReq[NP-1] |-> !dnWe);

  // R9: an acknowledge completes the access next cycle, not as refused
  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    ((dnReq & dnAck) != '0) |=> (rspDone && !rspBlocked));

  // R7: refused completion carries FFh and only comes with done
  a_r7_blocked_ff: assert property (@(posedge clk) disable iff (!rstN)
    rspBlocked |-> (rspDone && (rspData == '1)));

  // R3: internal RAM port only sees an 8-bit offset
  a_r3_iram_offset: assert property (@(posedge clk) disable iff (!rstN)
    dnReq[1] |-> (dnAddr[AW-2:8] == '0));

  // R4: extended RAM port only sees a 16-bit offset of at least 0100h
  a_r4_xram_offset: assert property (@(posedge clk) disable iff (!rstN)
    dnReq[2] |-> ((dnAddr[AW-2:16] == '0) && (dnAddr[15:8] != 8'h00)));
endmodule

bind uptr_router uptr_checker #(.AW(AW), .BW(BW), .NP(NP)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .dnReq      (dnReq),
  .dnAck      (dnAck),
  .dnWe       (dnWe),
  .dnAddr     (dnAddr),
  .dnWdata    (dnWdata),
  .rspDone    (rspDone),
  .rspBlocked (rspBlocked),
  .rspData    (rspData)
);

// File: tb/sim_uptr_router.sv
`timescale 1ns/1ps
module sim_uptr_router;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wideEn;
  logic        reqValid;
  logic        reqReady;
  logic        reqWrite;
  logic [23:0] reqPtr;
  logic [1:0]  reqDisp;
  logic [7:0]  reqWdata;
  logic        rspDone;
  logic        rspBlocked;
  logic [7:0]  rspData;
  logic [3:0]  dnReq;
  logic [3:0]  dnAck;
  logic        dnWe;
  logic [22:0] dnAddr;
  logic [7:0]  dnWdata;
  logic [31:0] dnRdata;
  logic [23:0] incPtr;
  logic [1:0]  incImm;
  logic [23:0] incResult;

  always #5 clk = ~clk;

  uptr_router u0 (.*);

  typedef struct {
    logic [7:0] data;
    logic       blk;
    logic       chkData;
    string      tag;
  } expItem_t;

  expItem_t sb[$];
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected completions
  always @(negedge clk) begin
    if (rstN && rspDone) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected completion", 32'(rspData), 32'hX);
      end else begin
        expItem_t e;
        e = sb.pop_front();
        check(rspBlocked == e.blk, {e.tag, " blocked flag"},
              32'(rspBlocked), 32'(e.blk));
        if (e.chkData)
          check(rspData == e.data, {e.tag, " data"}, 32'(rspData), 32'(e.data));
      end
    end
  end

  task automatic access(input logic [23:0] ptr, input logic [1:0] disp,
                        input logic we, input logic [7:0] wd, input logic wide,
                        input logic expBlk, input int expPort,
                        input logic [22:0] expAddr, input int delay,
                        input logic [7:0] rd, input string tag);
    expItem_t e;
    e.data    = expBlk ? 8'hFF : rd;
    e.blk     = expBlk;
    e.chkData = !we;
    e.tag     = tag;
    sb.push_back(e);
    @(negedge clk);
    wideEn = wide; reqWrite = we; reqPtr = ptr; reqDisp = disp;
    reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (expBlk) begin
      check(dnReq == 4'b0, {tag, " no downstream request"}, 32'(dnReq), 0);
      @(negedge clk);
    end else begin
      check(dnReq == 4'(1 << expPort), {tag, " port"}, 32'(dnReq), 32'(1 << expPort));
      check(dnAddr == expAddr, {tag, " offset"}, 32'(dnAddr), 32'(expAddr));
      check(dnWe == we, {tag, " write enable"}, 32'(dnWe), 32'(we));
      if (we) check(dnWdata == wd, {tag, " write data"}, 32'(dnWdata), 32'(wd));
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        check(dnReq == 4'(1 << expPort) && !reqReady, {tag, " R8 held"},
              32'(dnReq), 32'(1 << expPort));
      end
      dnRdata = 32'hA5A5A5A5;
      dnRdata[expPort*8 +: 8] = rd;
      dnAck[expPort] = 1'b1;
      @(negedge clk);
      dnAck = 4'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wideEn = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqPtr = '0; reqDisp = '0; reqWdata = '0; dnAck = '0;
    dnRdata = '0; incPtr = '0; incImm = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(dnReq == 4'b0, "R11 no request after reset", 32'(dnReq), 0);
    check(rspDone == 1'b0, "R11 done low after reset", 32'(rspDone), 0);
    check(reqReady == 1'b1, "R11 ready after reset", 32'(reqReady), 1);

    // R2 classic external window
    access(24'h001234, 2'd0, 0, 8'h00, 0, 0, 0, 23'h001234, 0, 8'h3C, "R2 ext read");
    // R7 crossing out of the 64 KB window with wide off
    access(24'h00FFFF, 2'd2, 0, 8'h00, 0, 1, 0, 23'h0, 0, 8'h00, "R7 ext high refused");
    // R12 same access with wide on, R1 carry into page 01
    access(24'h00FFFF, 2'd2, 0, 8'h00, 1, 0, 0, 23'h010001, 1, 8'h77, "R12 R1 ext high");
    // R3 displacement into upper internal RAM
    access(24'h7F007E, 2'd3, 0, 8'h00, 0, 0, 1, 23'h000081, 0, 8'h81, "R3 iram read");
    // R4 write crossing into extended RAM
    access(24'h7F00FF, 2'd1, 1, 8'hC3, 0, 0, 2, 23'h000100, 2, 8'h00, "R4 xram write");
    // R5 internal page end rolls into code offset 0, allowed with wide off
    access(24'h7FFFFF, 2'd1, 0, 8'h00, 0, 0, 3, 23'h000000, 0, 8'h02, "R5 code read");
    // R6 code write refused
    access(24'h800010, 2'd0, 1, 8'h99, 1, 1, 3, 23'h0, 0, 8'h00, "R6 code write");
    // R7 code above 64 KB with wide off
    access(24'h810000, 2'd0, 0, 8'h00, 0, 1, 3, 23'h0, 0, 8'h00, "R7 code high refused");
    // R12 same with wide on
    access(24'h810000, 2'd0, 0, 8'h00, 1, 0, 3, 23'h010000, 0, 8'h5E, "R12 code high");
    // R1 wrap through the top of the map
    access(24'hFFFFFE, 2'd3, 0, 8'h00, 0, 0, 0, 23'h000001, 0, 8'h4B, "R1 wrap");
    // R12 top of high external data
    access(24'h7EFFFF, 2'd0, 0, 8'h00, 1, 0, 0, 23'h7EFFFF, 0, 8'hE7, "R12 ext top");
    // R8 long acknowledge delay on a write
    access(24'h000055, 2'd0, 1, 8'h12, 0, 0, 0, 23'h000055, 4, 8'h00, "R8 delayed write");
    // R9 internal RAM lowest byte
    access(24'h7F0000, 2'd0, 0, 8'h00, 0, 0, 1, 23'h000000, 1, 8'hD0, "R9 iram read");

    // R10 pointer increment
    incPtr = 24'hFFFFFF; incImm = 2'd0;
    #1 check(incResult == 24'h000000, "R10 increment wrap", 32'(incResult), 0);
    incPtr = 24'h1234FE; incImm = 2'd3;
    #1 check(incResult == 24'h123502, "R10 increment by 4", 32'(incResult), 32'h123502);
    incPtr = 24'h7FFFFF; incImm = 2'd1;
    #1 check(incResult == 24'h800001, "R10 increment by 2", 32'(incResult), 32'h800001);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9 all completions seen", 32'(sb.size()), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule